// File: doc/BRIEF.md
# SD Host Command and Interrupt Status Unit

This block is the command and status slice of a simplified SD host controller. Software writes an argument and a command word over a simple register bus. The unit sends one request toward the card-side logic and then waits for that logic to return a response strobe, which carries a command index and a 32-bit card-status payload. The unit keeps a normal and an error interrupt status word. Each status word has a per-bit latch enable and a per-bit signal enable, and together they drive a single interrupt line.

Three behaviours are fixed by design. Commands can be issued straight after reset, because the unit has no power gate and needs no power-on write. The card-present flag is high after power-on reset and goes low for good on the first software reset. A response that arrives for a command that asked for none completes the command quietly: the payload is dropped and no error is raised. A response wait timer turns a missing reply into either a timeout error or, for commands that expect no reply, a normal completion.

Top module: `sdcmd_status_unit`

## Requirements
- R1: After power-on reset the status register (0x0C) reads 0, the state register (0x18) reads 0x2 (bit 1 = card present, bit 0 = busy), irq is low, and a command is accepted without any prior write to the host control register.
- R2: A write to the command register (0x04: index in bits 5:0, response kind in bits 9:8, kind 0 = none, kinds 1 to 3 expect a reply) while idle raises cmd_req_valid for exactly one cycle with the index, the kind and the argument from register 0x00, and sets busy.
- R3: A command write while busy is ignored: no request is issued, and the command register keeps the fields of the accepted command.
- R4: A response with a matching index to a command that expects one sets status bit 0 (done), clears busy, and places the payload in the response register (0x08).
- R5: A response whose index differs from the issued index, for a command that expects one, sets done, the index error bit (status bit 17), and the summary bit 15.
- R6: For a kind-0 command, a card response sets done with no error bit, and the response register keeps its old value.
- R7: When no response arrives within the timeout register value (0x1C) in cycles, a kind 1 to 3 command sets the timeout error (status bit 16) and summary bit 15 without done, and a kind-0 command sets done. Busy clears in both cases.
- R8: Writing 1 to a status bit clears it. A set and a clear of the same bit in the same cycle leave it set. Bit 15 is not writable and reads as the OR of the error bits.
- R9: A status bit whose latch enable (register 0x10, same bit layout as status) is 0 does not latch, and the command still completes.
- R10: irq is the OR over all status bits of each bit ANDed with its signal enable bit (register 0x14, same bit layout).
- R11: Writing 1 to bit 0 of the reset register (0x2C) clears busy, status and the response, and clears the card-present flag, which no later command or reset ever sets again.
- R12: The card-present flag never raises irq, whatever the signal enables are.
- R13: The host control register (0x28) keeps only bits 7:0. Writes to higher bits, including the power bit 8, have no effect and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address, used for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cmd_req_valid | output | 1 | One-cycle request toward the card side |
| cmd_req_index | output | 6 | Index of the issued command |
| cmd_req_arg | output | 32 | Argument of the issued command |
| cmd_req_kind | output | 2 | Response kind of the issued command |
| card_rsp_valid | input | 1 | Response strobe from the card side |
| card_rsp_index | input | 6 | Index field of the response |
| card_rsp_payload | input | 32 | Card-status field of the response |
| irq | output | 1 | Interrupt request |

## Verification
A response strobe and a write-one-to-clear of the done bit can reach the status register on the same clock edge. The bench drives both in one cycle and expects done to read back as 1 afterwards. A command write can also land while an earlier command is still busy. The scoreboard flags any request that it did not queue, and the command register readback must still show the first command.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;

  localparam int CMD_IDX_W = 6;
  localparam int KIND_LSB  = 8;

  localparam logic [7:0] OFS_ARG     = 8'h00;
  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_RESP    = 8'h08;
  localparam logic [7:0] OFS_STS     = 8'h0C;
  localparam logic [7:0] OFS_STS_EN  = 8'h10;
  localparam logic [7:0] OFS_SIG_EN  = 8'h14;
  localparam logic [7:0] OFS_STATE   = 8'h18;
  localparam logic [7:0] OFS_TMO     = 8'h1C;
  localparam logic [7:0] OFS_HOSTCTL = 8'h28;
  localparam logic [7:0] OFS_SWRST   = 8'h2C;

  // implemented status bits per half: done in the normal half,
  // timeout (bit 0) and index mismatch (bit 1) in the error half
  localparam logic [15:0] NORM_IMPL = 16'h0001;
  localparam logic [15:0] ERR_IMPL  = 16'h0003;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_SHORT      = 2'd1,
    RSP_SHORT_BUSY = 2'd2,
    RSP_LONG       = 2'd3
  } rsp_kind_e;

  function automatic logic rsp_wanted(input rsp_kind_e k);
    return k != RSP_NONE;
  endfunction

endpackage

// File: rtl/sdcs_cmd_engine.sv
module sdcs_cmd_engine
  import sdcs_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              issue_wr,
  input  logic [IDX_W-1:0]  wr_idx,
  input  rsp_kind_e         wr_kind,
  input  logic [DATA_W-1:0] arg_in,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_idx,
  output logic              busy,
  output logic              req_valid,
  output logic [IDX_W-1:0]  req_idx,
  output logic [DATA_W-1:0] req_arg,
  output rsp_kind_e         req_kind,
  output logic              ev_done,
  output logic              ev_timeout,
  output logic              ev_idx_err,
  output logic              ev_store
);

  function automatic logic index_bad(input logic want,
                                     input logic [IDX_W-1:0] issued,
                                     input logic [IDX_W-1:0] got);
    return want && (issued != got);
  endfunction

  logic              busy_q, req_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] arg_q;
  rsp_kind_e         kind_q;
  logic [TMO_W-1:0]  cnt_q;

  logic accept, rsp_hit, expired, want;

  assign want    = rsp_wanted(kind_q);
  assign accept  = issue_wr && !busy_q;
  assign rsp_hit = busy_q && rsp_valid;
  assign expired = busy_q && !rsp_valid && (cnt_q >= tmo_limit);

  assign ev_done    = rsp_hit || (expired && !want);
  assign ev_timeout = expired && want;
  assign ev_idx_err = rsp_hit && index_bad(want, idx_q, rsp_idx);
  assign ev_store   = rsp_hit && want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      idx_q  <= '0;
      arg_q  <= '0;
      kind_q <= RSP_NONE;
      cnt_q  <= '0;
    end else if (soft_rst) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      req_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= wr_idx;
        arg_q  <= arg_in;
        kind_q <= wr_kind;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (rsp_hit || expired) busy_q <= 1'b0;
        else                    cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign req_valid = req_q;
  assign req_idx   = idx_q;
  assign req_arg   = arg_q;
  assign req_kind  = kind_q;

endmodule

// File: rtl/sdcs_status_regs.sv
module sdcs_status_regs #(
  parameter int HALF_W = 16,
  parameter logic [HALF_W-1:0] NORM_MASK = '1,
  parameter logic [HALF_W-1:0] ERR_MASK  = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [HALF_W-1:0]   norm_set,
  input  logic [HALF_W-1:0]   err_set,
  input  logic                sts_clr_wr,
  input  logic                en_wr,
  input  logic                sig_wr,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [HALF_W-1:0]   norm_view,
  output logic [HALF_W-1:0]   err_sts,
  output logic [2*HALF_W-1:0] sts_en,
  output logic [2*HALF_W-1:0] sig_en,
  output logic                irq
);

  localparam logic [2*HALF_W-1:0] IMPL = {ERR_MASK, NORM_MASK};

  // set beats clear; unimplemented bits are held at zero by the mask
  function automatic logic [HALF_W-1:0] w1c_next(input logic [HALF_W-1:0] cur,
                                                 input logic [HALF_W-1:0] clr,
                                                 input logic [HALF_W-1:0] set,
                                                 input logic [HALF_W-1:0] en,
                                                 input logic [HALF_W-1:0] mask);
    return ((cur & ~clr) | (set & en)) & mask;
  endfunction

  logic [2*HALF_W-1:0] set_all, sts_all, en_q, sig_q;
  logic [HALF_W-1:0]   norm_sts;
  logic                err_sum;

  assign set_all = {err_set, norm_set};

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [HALF_W-1:0] M = (h == 0) ? NORM_MASK : ERR_MASK;
    logic [HALF_W-1:0] q;
    logic [HALF_W-1:0] clr;
    assign clr = sts_clr_wr ? wdata[h*HALF_W +: HALF_W] : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (soft_rst) q <= '0;
      else               q <= w1c_next(q, clr, set_all[h*HALF_W +: HALF_W],
                                       en_q[h*HALF_W +: HALF_W], M);
    end
    assign sts_all[h*HALF_W +: HALF_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= IMPL;
      sig_q <= '0;
    end else begin
      if (en_wr)  en_q  <= wdata & IMPL;
      if (sig_wr) sig_q <= wdata;
    end
  end

  assign norm_sts  = sts_all[HALF_W-1:0];
  assign err_sts   = sts_all[2*HALF_W-1:HALF_W];
  assign err_sum   = |err_sts;
  assign norm_view = {err_sum | norm_sts[HALF_W-1], norm_sts[HALF_W-2:0]};
  assign irq       = (|(norm_view & sig_q[HALF_W-1:0])) ||
                     (|(err_sts & sig_q[2*HALF_W-1:HALF_W]));
  assign sts_en    = en_q;
  assign sig_en    = sig_q;

endmodule

// File: rtl/sdcs_card_flag.sv
module sdcs_card_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  output logic present
);

  // set only by power-on reset; the first software reset drops it for good
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        present <= 1'b1;
    else if (soft_rst) present <= 1'b0;
  end

endmodule

// File: rtl/sdcmd_status_unit.sv
module sdcmd_status_unit
  import sdcs_pkg::*;
#(
  parameter int IDX_W     = CMD_IDX_W,
  parameter int DATA_W    = 32,
  parameter int TMO_W     = 16,
  parameter int TMO_RESET = 64,
  parameter int HOST_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cmd_req_valid,
  output logic [IDX_W-1:0]  cmd_req_index,
  output logic [DATA_W-1:0] cmd_req_arg,
  output logic [1:0]        cmd_req_kind,
  input  logic              card_rsp_valid,
  input  logic [IDX_W-1:0]  card_rsp_index,
  input  logic [DATA_W-1:0] card_rsp_payload,
  output logic              irq
);

  localparam int HALF_W = DATA_W / 2;
  localparam int GAP_W  = KIND_LSB - IDX_W;

  logic [DATA_W-1:0] arg_q, resp_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [HOST_W-1:0] hostctl_q;

  logic wr_cmd, wr_sts, wr_en_reg, wr_sig, soft_rst;
  logic busy, ev_done, ev_timeout, ev_idx_err, ev_store, card_ins, rsp_wanted_w;
  rsp_kind_e req_kind, wr_kind;
  logic [HALF_W-1:0]   norm_set, err_set, norm_view, err_sts;
  logic [2*HALF_W-1:0] sts_en, sig_en;

  assign wr_cmd    = reg_wr_en && (reg_addr == OFS_CMD);
  assign wr_sts    = reg_wr_en && (reg_addr == OFS_STS);
  assign wr_en_reg = reg_wr_en && (reg_addr == OFS_STS_EN);
  assign wr_sig    = reg_wr_en && (reg_addr == OFS_SIG_EN);
  assign soft_rst  = reg_wr_en && (reg_addr == OFS_SWRST) && reg_wdata[0];
  assign wr_kind   = rsp_kind_e'(reg_wdata[KIND_LSB +: 2]);

  sdcs_cmd_engine #(.IDX_W(IDX_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .issue_wr  (wr_cmd),
    .wr_idx    (reg_wdata[IDX_W-1:0]),
    .wr_kind   (wr_kind),
    .arg_in    (arg_q),
    .tmo_limit (tmo_q),
    .rsp_valid (card_rsp_valid),
    .rsp_idx   (card_rsp_index),
    .busy      (busy),
    .req_valid (cmd_req_valid),
    .req_idx   (cmd_req_index),
    .req_arg   (cmd_req_arg),
    .req_kind  (req_kind),
    .ev_done   (ev_done),
    .ev_timeout(ev_timeout),
    .ev_idx_err(ev_idx_err),
    .ev_store  (ev_store)
  );

  assign cmd_req_kind = req_kind;
  assign rsp_wanted_w = rsp_wanted(req_kind);
  assign norm_set     = HALF_W'(ev_done);
  assign err_set      = {{(HALF_W-2){1'b0}}, ev_idx_err, ev_timeout};

  sdcs_status_regs #(.HALF_W(HALF_W), .NORM_MASK(NORM_IMPL), .ERR_MASK(ERR_IMPL)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .norm_set  (norm_set),
    .err_set   (err_set),
    .sts_clr_wr(wr_sts),
    .en_wr     (wr_en_reg),
    .sig_wr    (wr_sig),
    .wdata     (reg_wdata),
    .norm_view (norm_view),
    .err_sts   (err_sts),
    .sts_en    (sts_en),
    .sig_en    (sig_en),
    .irq       (irq)
  );

  sdcs_card_flag u_card (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .present (card_ins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q     <= '0;
      resp_q    <= '0;
      tmo_q     <= TMO_W'(TMO_RESET);
      hostctl_q <= '0;
    end else if (soft_rst) begin
      resp_q    <= '0;
      hostctl_q <= '0;
    end else begin
      if (reg_wr_en && reg_addr == OFS_ARG)     arg_q     <= reg_wdata;
      if (reg_wr_en && reg_addr == OFS_TMO)     tmo_q     <= reg_wdata[TMO_W-1:0];
      if (reg_wr_en && reg_addr == OFS_HOSTCTL) hostctl_q <= reg_wdata[HOST_W-1:0];
      if (ev_store)                             resp_q    <= card_rsp_payload;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_ARG:     reg_rdata = arg_q;
      OFS_CMD:     reg_rdata = DATA_W'({req_kind, {GAP_W{1'b0}}, cmd_req_index});
      OFS_RESP:    reg_rdata = resp_q;
      OFS_STS:     reg_rdata = {err_sts, norm_view};
      OFS_STS_EN:  reg_rdata = sts_en;
      OFS_SIG_EN:  reg_rdata = sig_en;
      OFS_STATE:   reg_rdata = DATA_W'({card_ins, busy});
      OFS_TMO:     reg_rdata = DATA_W'(tmo_q);
      OFS_HOSTCTL: reg_rdata = DATA_W'(hostctl_q);
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sdcs_checker.sv
module sdcs_checker #(
  parameter int HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              busy,
  input logic              req_valid,
  input logic              ev_done,
  input logic              ev_timeout,
  input logic              ev_idx_err,
  input logic              rsp_wanted_w,
  input logic              card_ins,
  input logic [HALF_W-1:0] norm_view,
  input logic [HALF_W-1:0] err_sts,
  input logic              irq
);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);

  assert_no_reissue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !$past(busy));

  assert_done_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !soft_rst) |=> !busy);

  assert_idx_needs_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idx_err |-> rsp_wanted_w);

  assert_tmo_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |-> (!ev_done && rsp_wanted_w));

  assert_card_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !card_ins |=> !card_ins);

  assert_quiet_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_view == '0 && err_sts == '0) |-> !irq);

endmodule

bind sdcmd_status_unit sdcs_checker #(.HALF_W(HALF_W)) u_sdcs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .busy        (busy),
  .req_valid   (cmd_req_valid),
  .ev_done     (ev_done),
  .ev_timeout  (ev_timeout),
  .ev_idx_err  (ev_idx_err),
  .rsp_wanted_w(rsp_wanted_w),
  .card_ins    (card_ins),
  .norm_view   (norm_view),
  .err_sts     (err_sts),
  .irq         (irq)
);

// File: tb/sdcmd_status_unit_bench.sv
module sdcmd_status_unit_bench;

  localparam logic [7:0] A_ARG = 8'h00, A_CMD = 8'h04, A_RESP = 8'h08, A_STS = 8'h0C,
                         A_EN = 8'h10, A_SIG = 8'h14, A_STATE = 8'h18, A_TMO = 8'h1C,
                         A_HOST = 8'h28, A_RST = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n, reg_wr_en, card_rsp_valid;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, card_rsp_payload, reg_rdata, cmd_req_arg;
  logic [5:0]  card_rsp_index, cmd_req_index;
  logic [1:0]  cmd_req_kind;
  logic        cmd_req_valid, irq;

  int total = 0;
  int bad   = 0;
  logic [39:0] exp_q[$];

  always #10 clk = ~clk;

  sdcmd_status_unit u_sdcmd_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_req_valid(cmd_req_valid),
    .cmd_req_index(cmd_req_index), .cmd_req_arg(cmd_req_arg), .cmd_req_kind(cmd_req_kind),
    .card_rsp_valid(card_rsp_valid), .card_rsp_index(card_rsp_index),
    .card_rsp_payload(card_rsp_payload), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue the expected request, then write argument and command
  task automatic issue(input logic [5:0] idx, input logic [1:0] kind, input logic [31:0] arg);
    wr(A_ARG, arg);
    exp_q.push_back({kind, idx, arg});
    wr(A_CMD, {22'd0, kind, 2'b00, idx});
  endtask

  task automatic respond(input logic [5:0] idx, input logic [31:0] pay);
    @(negedge clk);
    card_rsp_valid = 1'b1; card_rsp_index = idx; card_rsp_payload = pay;
    @(negedge clk);
    card_rsp_valid = 1'b0;
  endtask

  // monitor: every request must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && cmd_req_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected request actual=%h expected=none",
                 {cmd_req_kind, cmd_req_index, cmd_req_arg});
      end else begin
        check("R2 request fields", {24'd0, cmd_req_kind, cmd_req_index, cmd_req_arg},
              {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    card_rsp_valid = 1'b0; card_rsp_index = '0; card_rsp_payload = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rdchk("R1 status", A_STS, 32'h0);
    rdchk("R1 state", A_STATE, 32'h2);
    check("R1 irq", irq, 0);
    wr(A_TMO, 32'd20);

    // R1/R2/R4 command straight after reset, no power write
    issue(6'd17, 2'd1, 32'h1234_5678);
    rdchk("R2 busy", A_STATE, 32'h3);
    respond(6'd17, 32'hCAFE_0001);
    rdchk("R4 done", A_STS, 32'h0000_0001);
    rdchk("R4 response", A_RESP, 32'hCAFE_0001);
    rdchk("R4 idle", A_STATE, 32'h2);

    // R13 host control: only bits 7:0 stick, power bit 8 ignored
    wr(A_HOST, 32'hFFFF_FFFF);
    rdchk("R13 host ctrl", A_HOST, 32'h0000_00FF);

    // R3 second command while busy is ignored
    wr(A_STS, 32'hFFFF_FFFF);
    issue(6'd5, 2'd1, 32'hA5A5_0005);
    wr(A_CMD, {22'd0, 2'd2, 2'b00, 6'd9});
    rdchk("R3 command kept", A_CMD, 32'h0000_0105);
    respond(6'd5, 32'h0000_0011);
    rdchk("R3 one completion", A_STS, 32'h0000_0001);

    // R8 set and clear of done in the same cycle: set wins
    wr(A_STS, 32'h0000_0001);
    rdchk("R8 w1c clears", A_STS, 32'h0);
    issue(6'd7, 2'd1, 32'h0000_0007);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = A_STS; reg_wdata = 32'h0000_0001;
    card_rsp_valid = 1'b1; card_rsp_index = 6'd7; card_rsp_payload = 32'h7777_0007;
    @(negedge clk);
    reg_wr_en = 1'b0; card_rsp_valid = 1'b0;
    rdchk("R8 set beats clear", A_STS, 32'h0000_0001);

    // R5 index mismatch
    wr(A_STS, 32'hFFFF_FFFF);
    issue(6'd8, 2'd1, 32'h0000_0008);
    respond(6'd9, 32'h0000_BEEF);
    rdchk("R5 index error", A_STS, 32'h0002_8001);
    rdchk("R5 response kept", A_RESP, 32'h0000_BEEF);
    wr(A_STS, 32'h0000_8000);
    rdchk("R8 bit15 read-only", A_STS, 32'h0002_8001);
    wr(A_STS, 32'hFFFF_FFFF);
    rdchk("R8 all cleared", A_STS, 32'h0);

    // R6 unwanted response completes quietly
    issue(6'd23, 2'd0, 32'h0000_0023);
    respond(6'd23, 32'h0000_DEAD);
    rdchk("R6 done no error", A_STS, 32'h0000_0001);
    rdchk("R6 response dropped", A_RESP, 32'h0000_BEEF);

    // R7 timeout with an expected reply
    wr(A_STS, 32'hFFFF_FFFF);
    issue(6'd2, 2'd1, 32'h0000_0002);
    idle(10);
    rdchk("R7 still waiting", A_STATE, 32'h3);
    idle(15);
    rdchk("R7 timeout error", A_STS, 32'h0001_8000);
    rdchk("R7 busy cleared", A_STATE, 32'h2);

    // R7 kind none without reply completes
    wr(A_STS, 32'hFFFF_FFFF);
    issue(6'd0, 2'd0, 32'h0);
    idle(25);
    rdchk("R7 none completes", A_STS, 32'h0000_0001);

    // R9 latch enable off for done
    wr(A_STS, 32'hFFFF_FFFF);
    wr(A_EN, 32'hFFFF_FFFE);
    issue(6'd3, 2'd3, 32'h0000_0003);
    respond(6'd3, 32'h0000_0033);
    rdchk("R9 masked bit", A_STS, 32'h0);
    rdchk("R9 completes", A_STATE, 32'h2);
    wr(A_EN, 32'hFFFF_FFFF);

    // R10 interrupt line
    wr(A_SIG, 32'h0000_0001);
    check("R10 irq low", irq, 0);
    issue(6'd11, 2'd1, 32'h0000_000B);
    respond(6'd11, 32'h0000_00BB);
    check("R10 irq on done", irq, 1);
    wr(A_STS, 32'h0000_0001);
    check("R10 irq after clear", irq, 0);
    wr(A_SIG, 32'h0000_8000);
    issue(6'd12, 2'd1, 32'h0000_000C);
    respond(6'd13, 32'h0000_00CC);
    check("R10 irq on summary", irq, 1);
    wr(A_STS, 32'hFFFF_FFFF);
    check("R10 irq cleared", irq, 0);

    // R12 card-present never interrupts
    wr(A_SIG, 32'hFFFF_FFFF);
    rdchk("R12 card present", A_STATE, 32'h2);
    check("R12 irq quiet", irq, 0);

    // R11 soft reset mid-command
    issue(6'd4, 2'd1, 32'h0000_0004);
    wr(A_RST, 32'h1);
    rdchk("R11 state", A_STATE, 32'h0);
    rdchk("R11 status", A_STS, 32'h0);
    rdchk("R11 response", A_RESP, 32'h0);
    issue(6'd6, 2'd1, 32'h0000_0006);
    respond(6'd6, 32'h0000_0066);
    rdchk("R11 card stays low", A_STATE, 32'h0);
    wr(A_RST, 32'h1);
    rdchk("R11 card after second reset", A_STATE, 32'h0);

    check("R2 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule